// File: doc/BRIEF.md
# Prescaled Low-First PWM Generator

This block produces one pulse-width-modulated output from a small set of write-only configuration registers. A prescaler divides the input clock by 1, 2, 4 or 8. A period counter advances once per divided tick. It counts from zero up to the programmed cycle value, so one period lasts the cycle value plus one ticks. In each period the output is driven low first, for the programmed low time, and then high for the rest of the period. An invert control swaps the two levels.

Software writes the registers through a plain write strobe with an address and a data word. This is a single-beat control path with no back-pressure: every strobed write is taken in the cycle it is presented. The cycle register can be written only while the counter is stopped. A write to it while the counter runs is dropped. A new low time is taken into use at the next period boundary, so a period is never cut short or stretched by a write. A period that is fully low needs a low time greater than the cycle value. Both registers are 24 bits wide, so a cycle value of 0xFFFFFF cannot give a fully low period.

Top module: `lfpwm_top`

## Requirements
- R1: While reset is held and after reset is released, `pwm_out` is 0 and the counter is stopped. All registers reset to 0.
- R2: While running, one period lasts (cycle + 1) × 2^div_sel input clocks. `div_sel` is control bits [3:2]: 0, 1, 2 and 3 select ratios 1, 2, 4 and 8. The count starts at 0 when the counter is enabled.
- R3: With invert at 0, the output is 0 while the in-period count is less than the active low time and 1 otherwise. Each period therefore starts low.
- R4: A low time greater than the cycle value keeps the output low for the whole period. A low time of 0 keeps it high for the whole period. A low time equal to the cycle value gives a single high tick at the end of each period.
- R5: Control bit 1 (invert) inverts the output level in every phase.
- R6: Control bit 0 (enable) runs the counter. While it is 0, the counter and prescaler are held at 0 and the output rests at the invert bit's value. Setting it again starts a fresh period from count 0.
- R7: A write to the cycle register while enable is 1 is dropped and the old period is kept. The same write while enable is 0 is stored.
- R8: A low-time write made during a period leaves the rest of that period unchanged. The new value applies from the next period.
- R9: Register addresses are 0 for control, 1 for cycle (data bits [23:0]) and 2 for low time (data bits [23:0]). Data bits above the field are ignored. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 32 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The embedded assertions check the following on every cycle: the count never passes the cycle value while running, it returns to zero after the last tick of a period, the active low time holds steady inside a period, the cycle register cannot change while running, and a stopped counter stays at zero. The exact waveform can only be shown by the bench scenarios. These cover low-first timing at each division ratio, inversion, the fully low, fully high and single-high-tick cases, rejection of a locked cycle write at the output, the boundary at which a low-time update starts to apply, and the idle level after stopping.

// File: rtl/lfpwm_pkg.sv
package lfpwm_pkg;

  localparam int unsigned ADDR_W = 2;

  // register addresses; the control field positions below are decoded by lfpwm_regs
  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_CYCLE = 2'd1,
    REG_LOW   = 2'd2,
    REG_SPARE = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_INV_BIT = 1;
  localparam int unsigned CTRL_DIV_LSB = 2;

endpackage

// File: rtl/lfpwm_regs.sv
module lfpwm_regs
  import lfpwm_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIV_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 run,
  output logic                 invert,
  output logic [DIV_SEL_W-1:0] div_sel,
  output logic [CNT_W-1:0]     cycle,
  output logic [CNT_W-1:0]     low_time
);

  logic                 run_q, inv_q;
  logic [DIV_SEL_W-1:0] div_q;
  logic [CNT_W-1:0]     cycle_q, low_q;

  // upper data bits have no register behind them (R9)
  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      inv_q   <= 1'b0;
      div_q   <= '0;
      cycle_q <= '0;
      low_q   <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        REG_CTRL: begin
          run_q <= wr_data[CTRL_RUN_BIT];
          inv_q <= wr_data[CTRL_INV_BIT];
          div_q <= wr_data[CTRL_DIV_LSB +: DIV_SEL_W];
        end
        REG_CYCLE: begin
          // period lock: only a stopped counter accepts a new cycle value (R7)
          if (!run_q) cycle_q <= wr_data[CNT_W-1:0];
        end
        REG_LOW:   low_q <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign run      = run_q;
  assign invert   = inv_q;
  assign div_sel  = div_q;
  assign cycle    = cycle_q;
  assign low_time = low_q;

  assert_cycle_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(cycle_q));

endmodule

// File: rtl/lfpwm_prescale.sv
module lfpwm_prescale #(
  parameter int unsigned DIV_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 tick
);

  localparam int unsigned MAX_SHIFT = (1 << DIV_SEL_W) - 1;
  localparam int unsigned PW        = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [PW-1:0] pcnt;
  logic [PW:0]   ratio, limit;

  always_comb begin
    ratio = (PW+1)'(1) << div_sel;
    limit = ratio - (PW+1)'(1);
  end

  // ">=" keeps the divider safe if the ratio is lowered while running
  assign tick = run && ({1'b0, pcnt} >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pcnt <= '0;
    else if (tick)      pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end

  assert_prescale_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pcnt == '0);

endmodule

// File: rtl/lfpwm_core.sv
module lfpwm_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             invert,
  input  logic             tick,
  input  logic [CNT_W-1:0] cycle,
  input  logic [CNT_W-1:0] low_time,
  output logic             pwm_out
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] low_act;   // low time in force for the current period
  logic             wrap;

  assign wrap = tick && (cnt == cycle);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      low_act <= '0;
    end else if (!run) begin
      cnt     <= '0;
      low_act <= low_time;
    end else if (tick) begin
      if (wrap) begin
        cnt     <= '0;
        low_act <= low_time;   // period boundary: take the new low time (R8)
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // low phase first, then high; idle level is low before inversion
  assign pwm_out = (run && (cnt >= low_act)) ^ invert;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= cycle);

  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wrap) |=> cnt == '0);

  assert_low_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(low_act));

  assert_counter_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  assert_full_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (low_act > cycle)) |-> pwm_out == invert);

endmodule

// File: rtl/lfpwm_top.sv
module lfpwm_top
  import lfpwm_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIV_SEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out
);

  logic                 run, invert, tick;
  logic [DIV_SEL_W-1:0] div_sel;
  logic [CNT_W-1:0]     cycle, low_time;

  lfpwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .DIV_SEL_W(DIV_SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .invert(invert), .div_sel(div_sel), .cycle(cycle), .low_time(low_time)
  );

  lfpwm_prescale #(.DIV_SEL_W(DIV_SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .tick(tick)
  );

  lfpwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .invert(invert), .tick(tick),
    .cycle(cycle), .low_time(low_time), .pwm_out(pwm_out)
  );

  assert_reset_out_R1: assert property (@(posedge clk)
    !rst_n |=> pwm_out == 1'b0);

endmodule

// File: tb/sim_lfpwm_top.sv
module sim_lfpwm_top;
  import lfpwm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // scoreboard: one expected output level per input clock
  bit    q_val[$];
  string q_tag[$];

  always #5 clk = ~clk;

  lfpwm_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                .wr_data(wr_data), .pwm_out(pwm_out));

  task automatic check(input bit exp, input string tag);
    checks++;
    if (pwm_out !== exp) begin
      errors++;
      $display("FAIL %s: pwm_out=%0b expected %0b at %0t", tag, pwm_out, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: pops one expected level per clock, just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_val.size() > 0) begin
        bit    e;
        string t;
        e = q_val.pop_front();
        t = q_tag.pop_front();
        check(e, t);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctrl(input bit en, input bit inv, input int sel);
    return {28'd0, 2'(sel), inv, en};
  endfunction

  // driver side: expected levels of one period, low phase first
  task automatic push_period(input int cyc, input int low, input int sel,
                             input bit inv, input string tag);
    for (int c = 0; c <= cyc; c++)
      for (int k = 0; k < (1 << sel); k++) begin
        q_val.push_back(((c < low) ? 1'b0 : 1'b1) ^ inv);
        q_tag.push_back(tag);
      end
  endtask

  task automatic push_idle(input bit inv, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      q_val.push_back(inv);
      q_tag.push_back(tag);
    end
  endtask

  task automatic drain();
    while (q_val.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(input logic [31:0] cyc_word, input int cyc, input int low,
                          input int sel, input bit inv, input int nper, input string tag);
    wr(REG_CTRL, ctrl(1'b0, inv, sel));
    wr(REG_CYCLE, cyc_word);
    wr(REG_LOW, low);
    wr(REG_CTRL, ctrl(1'b1, inv, sel));
    for (int p = 0; p < nper; p++) push_period(cyc, low, sel, inv, tag);
    drain();
  endtask

  task automatic stop_case(input bit inv, input string tag);
    wr(REG_CTRL, ctrl(1'b0, inv, 0));
    push_idle(inv, 4, tag);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  initial begin
    // R1: reset level, during and after reset
    repeat (3) @(negedge clk);
    check(1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, "R1 after reset");

    // R3/R2/R9: basic low-first waveform, ratio 1
    run_case(32'd9, 9, 3, 0, 1'b0, 2, "R3 basic low-first");
    // R2: division ratios 2, 4 and 8
    run_case(32'd3, 3, 1, 1, 1'b0, 2, "R2 ratio 2");
    run_case(32'd5, 5, 2, 2, 1'b0, 2, "R2 ratio 4");
    run_case(32'd2, 2, 1, 3, 1'b0, 2, "R2 ratio 8");
    // R5: inverted output, then R6 idle level with invert set
    run_case(32'd6, 6, 2, 0, 1'b1, 2, "R5 inverted");
    stop_case(1'b1, "R6 idle inverted");
    stop_case(1'b0, "R6 idle normal");
    // R4: fully low, fully high, single high tick
    run_case(32'd5, 5, 8, 0, 1'b0, 2, "R4 low greater than cycle");
    run_case(32'd5, 5, 0, 1, 1'b0, 2, "R4 zero low time");
    run_case(32'd5, 5, 5, 0, 1'b0, 2, "R4 low equals cycle");
    // R9: data bits above the cycle field are ignored
    run_case(32'hFF00_0003, 3, 1, 0, 1'b0, 2, "R9 upper data bits");

    // R8, R7, R9: writes while running
    wr(REG_CTRL, ctrl(1'b0, 1'b0, 0));
    wr(REG_CYCLE, 32'd9);
    wr(REG_LOW, 32'd3);
    wr(REG_CTRL, ctrl(1'b1, 1'b0, 0));
    push_period(9, 3, 0, 1'b0, "R8 current period keeps old low time");
    push_period(9, 7, 0, 1'b0, "R7 R8 locked cycle, new low time");
    push_period(9, 7, 0, 1'b0, "R9 spare address write ignored");
    repeat (2) @(negedge clk);
    wr(REG_LOW, 32'd7);       // committed mid period 0
    wr(REG_CYCLE, 32'd4);     // rejected: counter is running (R7)
    wr(REG_SPARE, 32'hFFFF_FFFF); // no effect (R9)
    drain();

    // R7: a stopped counter accepts the cycle write; R6: restart from count 0
    stop_case(1'b0, "R6 idle after stop");
    wr(REG_CYCLE, 32'd4);
    wr(REG_CTRL, ctrl(1'b1, 1'b0, 0));
    push_period(4, 7, 0, 1'b0, "R7 cycle accepted while stopped");
    push_period(4, 7, 0, 1'b0, "R7 cycle accepted while stopped");
    drain();
    run_case(32'd4, 4, 2, 0, 1'b0, 1, "R6 restart at count 0");

    report();
  end

endmodule